// File: doc/BRIEF.md
# Bidirectional Polarity-Controlled Row Driver

This block is the logic core of a display row driver. A serial bit stream loads a chain of 34 storage stages. Each stage controls one output channel. Every channel can be in one of three states: driven high, driven low or floating. A channel floats when its stored bit is 0 or when the global output enable is low. When the enable is high and the stored bit is 1, the channel drives the level that the global polarity input selects. Each channel leaves the block as a drive-enable bit and a drive-level bit. The high-voltage stages downstream turn these two bits into the real output.

The shift clock is a slow input, up to 4 MHz. The block samples it on its fast system clock `clk`, and the shift clock must be synchronous to `clk`. The chain advances once for each high-to-low transition seen on the shift clock. At that same sample the block captures the serial data bit and the direction input. With direction low, data enters at stage 1 and moves toward stage 34. With direction high, data enters at stage 34 and moves toward stage 1. The serial output is always the stage at the far end of the chain for the direction in use, so several devices can be chained in series. The outputs are decoded straight from the stages, with no transfer latch in between.

Top module: `row_drive_top`

## Requirements
- R1: While `rstN` is low, all stages clear to 0 at once, without waiting for a clock. As a result `driveEn` is all zero and `serOut` is 0.
- R2: A shift step happens at a `clk` rising edge where `shiftClk` is sampled low and was sampled high at the previous rising edge. After reset, the previous sample counts as low. At every other edge the stages and `serOut` keep their values.
- R3: In a shift step with `dirRev` = 0, stage n moves to stage n+1 and `serIn` enters stage 1. Stage k is bit k-1 of `driveEn`. After the step, `serOut` shows stage 34.
- R4: In a shift step with `dirRev` = 1, stage n moves to stage n-1 and `serIn` enters stage 34. After the step, `serOut` shows stage 1.
- R5: `dirRev` is sampled only at a shift step. Changing it between steps moves neither the data nor the `serOut` tap.
- R6: When `outEn` = 0, every bit of `driveEn` is 0, whatever is stored.
- R7: When `outEn` = 1, bit k-1 of `driveEn` equals stage k. Every bit where `driveEn` is 1 has a `driveLevel` equal to `polHigh`, which gives 1 for high drive and 0 for low drive.
- R8: `driveEn` and `driveLevel` are combinational in the stages, `outEn` and `polHigh`. A shift step changes them in the same cycle as the stages. A change on `outEn` or `polHigh` appears with no clock at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftClk | input | 1 | Shift clock; a falling transition starts a step |
| serIn | input | 1 | Serial data in |
| dirRev | input | 1 | Shift direction: 0 moves toward stage 34, 1 moves toward stage 1 |
| outEn | input | 1 | Global output enable |
| polHigh | input | 1 | Global drive polarity |
| serOut | output | 1 | Serial data out for cascading |
| driveEn | output | 34 | Per-channel drive enable |
| driveLevel | output | 34 | Per-channel drive level, meaningful where enabled |

## Verification
A shift step and a change of output enable, polarity or direction can fall in the same `clk` cycle. When they do, the outputs after the edge must combine the new stage contents with the new control values, and the serial tap must follow the direction captured at that step. The bench provokes this with a directed pass that toggles `outEn`, `polHigh` and `dirRev` exactly at the falling sample of `shiftClk`. Random stimulus adds many more such coincidences. A bench model updates its own stages and tap at the same sample and judges every cycle against them.

// File: rtl/row_drive_pkg.sv
package row_drive_pkg;
  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic step;    // a falling shift-clock transition was seen
    logic dirRev;  // direction captured with the step
  } shiftStrobe_t;
endpackage

// File: rtl/row_drive_ctl.sv
module row_drive_ctl
  import row_drive_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         shiftClk,
  input  logic         dirRev,
  output shiftStrobe_t strobe
);
  logic shiftPrev;

  // previous sample of the shift clock; low after reset so no false step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftPrev <= 1'b0;
    else       shiftPrev <= shiftClk;
  end

  always_comb begin
    strobe.step   = shiftPrev & ~shiftClk;
    strobe.dirRev = dirRev;
  end
endmodule

// File: rtl/row_drive_chain_dp.sv
module row_drive_chain_dp
  import row_drive_pkg::*;
#(
  parameter int NUM_STAGES = 34
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  shiftStrobe_t          strobe,
  input  logic                  serIn,
  output logic [NUM_STAGES-1:0] stageQ,
  output logic                  serOut
);
  localparam int LAST = NUM_STAGES - 1;

  logic dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
      dirQ   <= 1'b0;
    end else if (strobe.step) begin
      dirQ <= strobe.dirRev;
      if (strobe.dirRev) stageQ <= {serIn, stageQ[LAST:1]};
      else               stageQ <= {stageQ[LAST-1:0], serIn};
    end
  end

  // tap follows the direction of the last step, so it only moves on a step
  assign serOut = dirQ ? stageQ[0] : stageQ[LAST];
endmodule

// File: rtl/row_drive_out.sv
module row_drive_out #(
  parameter int NUM_STAGES = 34
) (
  input  logic [NUM_STAGES-1:0] stageQ,
  input  logic                  outEn,
  input  logic                  polHigh,
  output logic [NUM_STAGES-1:0] driveEn,
  output logic [NUM_STAGES-1:0] driveLevel
);
  for (genvar ch = 0; ch < NUM_STAGES; ch++) begin : g_chan
    assign driveEn[ch]    = outEn & stageQ[ch];
    assign driveLevel[ch] = stageQ[ch] & polHigh;
  end
endmodule

// File: rtl/row_drive_top.sv
module row_drive_top
  import row_drive_pkg::*;
#(
  parameter int NUM_STAGES = 34
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  shiftClk,
  input  logic                  serIn,
  input  logic                  dirRev,
  input  logic                  outEn,
  input  logic                  polHigh,
  output logic                  serOut,
  output logic [NUM_STAGES-1:0] driveEn,
  output logic [NUM_STAGES-1:0] driveLevel
);
  shiftStrobe_t          strobe;
  logic [NUM_STAGES-1:0] stageQ;

  row_drive_ctl ctl_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .dirRev(dirRev), .strobe(strobe)
  );

  row_drive_chain_dp #(.NUM_STAGES(NUM_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serIn(serIn),
    .stageQ(stageQ), .serOut(serOut)
  );

  row_drive_out #(.NUM_STAGES(NUM_STAGES)) out_i (
    .stageQ(stageQ), .outEn(outEn), .polHigh(polHigh),
    .driveEn(driveEn), .driveLevel(driveLevel)
  );
endmodule

// File: rtl/row_drive_checker.sv
module row_drive_checker #(
  parameter int NUM_STAGES = 34
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  shiftClk,
  input logic                  serIn,
  input logic                  dirRev,
  input logic                  outEn,
  input logic                  polHigh,
  input logic                  serOut,
  input logic [NUM_STAGES-1:0] driveEn,
  input logic [NUM_STAGES-1:0] driveLevel,
  input logic [NUM_STAGES-1:0] stageQ
);
  localparam int LAST = NUM_STAGES - 1;

  logic seenHigh;
  logic fallNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenHigh <= 1'b0;
    else       seenHigh <= shiftClk;
  end
  assign fallNow = seenHigh & ~shiftClk;

  assert_hold_no_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fallNow |=> ($stable(stageQ) && $stable(serOut)));

  assert_shift_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fallNow && !dirRev) |=> (stageQ == {$past(stageQ[LAST-1:0]), $past(serIn)}
                              && serOut == $past(stageQ[LAST-1])));

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fallNow && dirRev) |=> (stageQ == {$past(serIn), $past(stageQ[LAST:1])}
                             && serOut == $past(stageQ[1])));

  assert_float_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (driveEn == '0));

  assert_level_polarity_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> ((driveLevel & driveEn) == (polHigh ? driveEn : '0)));

  assert_no_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> (driveEn == stageQ));
endmodule

bind row_drive_top row_drive_checker #(.NUM_STAGES(NUM_STAGES)) chk_i (
  .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .serIn(serIn), .dirRev(dirRev),
  .outEn(outEn), .polHigh(polHigh), .serOut(serOut), .driveEn(driveEn),
  .driveLevel(driveLevel), .stageQ(stageQ)
);

// File: tb/row_drive_top_tb.sv
`timescale 1ns/1ps
module row_drive_top_tb_top;
  localparam int N = 34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0, serIn = 1'b0, dirRev = 1'b0, outEn = 1'b0, polHigh = 1'b0;
  logic serOut;
  logic [N-1:0] driveEn, driveLevel;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  // bench model
  logic [N-1:0] mStage = '0;
  logic mDir = 1'b0;
  logic mPrev = 1'b0;

  always #2.5 clk = ~clk;

  row_drive_top dut_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .serIn(serIn), .dirRev(dirRev),
    .outEn(outEn), .polHigh(polHigh), .serOut(serOut),
    .driveEn(driveEn), .driveLevel(driveLevel)
  );

  function automatic logic [N-1:0] expEn(logic [N-1:0] st, logic en);
    return en ? st : '0;
  endfunction

  function automatic logic [N-1:0] expLvl(logic [N-1:0] en, logic pol);
    return pol ? en : '0;
  endfunction

  function automatic logic expSer(logic [N-1:0] st, logic d);
    return d ? st[0] : st[N-1];
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp, string what);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [N-1:0] e;
    e = expEn(mStage, outEn);
    check(tag, driveEn, e, "driveEn");
    check(tag, driveLevel & driveEn, expLvl(e, polHigh), "driveLevel");
    check(tag, {{(N-1){1'b0}}, serOut}, {{(N-1){1'b0}}, expSer(mStage, mDir)}, "serOut");
  endtask

  // one clk cycle: drive at negedge, model at posedge, sample 1 ns later
  task automatic cyc(logic sc, logic si, logic dr, logic oe, logic pl, string tag);
    @(negedge clk);
    shiftClk = sc; serIn = si; dirRev = dr; outEn = oe; polHigh = pl;
    @(posedge clk);
    if (mPrev && !sc) begin
      mDir = dr;
      if (dr) mStage = {si, mStage[N-1:1]};
      else    mStage = {mStage[N-2:0], si};
    end
    mPrev = sc;
    #1;
    checkAll(tag);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    #1;
    checkAll("R1");
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1; outEn = 1'b1;
    #0.5 checkAll("R1");

    // R3: load a pattern moving toward stage 34, outputs enabled, high polarity
    for (int b = 0; b < N + 3; b++) begin
      cyc(1'b1, b[0] ^ b[2], 1'b0, 1'b1, 1'b1, "R3");
      cyc(1'b0, b[0] ^ b[2], 1'b0, 1'b1, 1'b1, "R3");
    end
    // R2: shift clock held low, rising edge and data wiggle without a fall
    for (int k = 0; k < 6; k++) cyc(1'b0, k[0], 1'b0, 1'b1, 1'b0, "R2");
    for (int k = 0; k < 6; k++) cyc(1'b1, k[0], 1'b0, 1'b1, 1'b0, "R2");
    // R5: direction flips between steps, tap must stay
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, k[0], 1'b1, 1'b1, "R5");
    // R4: shift toward stage 1
    for (int b = 0; b < N + 2; b++) begin
      cyc(1'b1, b[1], 1'b1, 1'b1, 1'b0, "R4");
      cyc(1'b0, b[1], 1'b1, 1'b1, 1'b0, "R4");
    end
    // R6: disabled outputs float
    for (int k = 0; k < 4; k++) cyc(k[0], 1'b1, 1'b0, 1'b0, k[1], "R6");
    // R8: coincident step with enable, polarity and direction change
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 1'b0, k[0], ~k[1], k[2], "R8");
      cyc(1'b0, 1'b1, ~k[0], k[1], ~k[2], "R8");
    end
    // R7: random mix
    for (int k = 0; k < 3000; k++) begin
      logic sc;
      sc = ($urandom % 3 != 0) ? ~shiftClk : shiftClk;
      cyc(sc, 1'($urandom), 1'($urandom), ($urandom % 4 != 0), 1'($urandom), "R7");
    end
    // R1: asynchronous reset mid-run
    @(negedge clk); rstN = 1'b0; mStage = '0; mDir = 1'b0; mPrev = 1'b0;
    #1 checkAll("R1");
    done = 1'b1;
    report();
  end
endmodule